// File: doc/BRIEF.md
# Selectable Clock Activity Detector

This block tells software whether one chosen clock is toggling. Twelve candidate clocks come in as three groups of four: receive-line clocks, transmit-line clocks and reference clocks. Software writes a source index into a single 8-bit control/status register. The block routes that clock to a toggle flop and carries the flop's output into the register clock domain through a two-stage synchronizer. Any change it sees on the synchronized toggle sets a sticky activity flag, which reads back in bit 7 of the same register.

A write restarts the check. It loads the index, clears the flag and opens a fresh observation window of 256 register-clock cycles. The first three cycles of the window are blanked, so that a glitch from switching the multiplexer cannot count as activity. After the window ends the flag is frozen until the next write. The block says only whether a clock is present. It does not measure or qualify the clock's frequency. The usual use is to confirm that a clock is alive before it is made a timing source.

Top module: `clkActivityMonitor`

## Requirements
- R1: The source index maps to clocks as follows: index 0–3 selects `rxLineClk[0..3]`, 4–7 selects `txLineClk[0..3]`, and 8–11 selects `refClk[0..3]`. A toggling selected clock drives bit 7 to 1. A stopped selected clock leaves bit 7 at 0.
- R2: A write (`wrEn` high at a rising `clk` edge) stores `wrData[3:0]` as the index. From the next cycle `rdData[3:0]` returns the stored index and `rdData[6:4]` reads 0. `wrData[7:4]` has no effect.
- R3: A write clears bit 7 in the cycle after the write edge.
- R4: Once bit 7 is 1, it stays 1 until the next write, even if the clock stops.
- R5: Bit 7 rises only when an armed cycle sees a change on the synchronized toggle. Such a change sets bit 7 on the third `clk` rising edge after the selected clock's rising edge.
- R6: Indices 12–15 select no clock, and bit 7 stays 0 while one of them is stored.
- R7: During the first three cycles after a write, detected changes are ignored. A level step caused by switching the multiplexer therefore does not set bit 7.
- R8: The window is armed from cycle 3 to cycle 255 after a write. A clock that starts only after the window closes leaves bit 7 at 0 until the next write.
- R9: While `rstN` is low, `rdData` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxLineClk | input | 4 | Receive-line clock candidates, indices 0–3 |
| txLineClk | input | 4 | Transmit-line clock candidates, indices 4–7 |
| refClk | input | 4 | Reference clock candidates, indices 8–11 |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Write data; bits 3:0 hold the source index |
| rdData | output | 8 | Bit 7 is the activity flag, bits 3:0 the stored index, bits 6:4 read zero |

## Verification
The field and flag changes caused by a write are due one `clk` edge after that write. Activity is due on the third `clk` edge after a rising edge of the selected clock. The bench steps all candidate clocks only on falling edges of `clk`, so the toggle flop changes half a cycle before it is sampled. The behavioural model then advances once per rising edge, one time unit after it, and compares `rdData` at that point every cycle. Checks at the end of each phase sample only after the 256-cycle window or a 40-cycle settle interval.

// File: rtl/clkact_pkg.sv
package clkact_pkg;
  localparam int SEL_W = 4;

  typedef struct packed {
    logic             clearFlag;
    logic             armed;
    logic [SEL_W-1:0] selIdx;
  } ctlStrobe_t;
endpackage

// File: rtl/clkActControl.sv
module clkActControl
  import clkact_pkg::*;
#(
  parameter int TOTAL_SRC   = 12,
  parameter int WINDOW_CYC  = 256,
  parameter int SETTLE_CYC  = 3,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output ctlStrobe_t        strobes
);
  localparam int CNT_W = $clog2(WINDOW_CYC + 1);
  localparam logic [CNT_W-1:0] WIN_END   = CNT_W'(WINDOW_CYC);
  localparam logic [CNT_W-1:0] SETTLE_END = CNT_W'(SETTLE_CYC);

  logic [SEL_W-1:0] selReg;
  logic [CNT_W-1:0] winCnt;
  logic             selValid;
  logic             inWindow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= '0;
      winCnt <= WIN_END;
    end else if (wrEn) begin
      selReg <= wrData[SEL_W-1:0];
      winCnt <= '0;
    end else if (winCnt != WIN_END) begin
      winCnt <= winCnt + 1'b1;
    end
  end

  always_comb begin
    selValid = (int'(selReg) < TOTAL_SRC);
    inWindow = (winCnt >= SETTLE_END) && (winCnt < WIN_END);
    strobes.clearFlag = wrEn;
    strobes.armed     = selValid && inWindow && !wrEn;
    strobes.selIdx    = selReg;
  end

  // R2: stored index follows the written low nibble
  p_sel_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (strobes.selIdx == $past(wrData[SEL_W-1:0])));

  // R7: settle blanking right after a write
  p_settle_blank_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !strobes.armed);

  // R2: index holds without a write
  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(strobes.selIdx));
endmodule

// File: rtl/clkActDatapath.sv
module clkActDatapath
  import clkact_pkg::*;
#(
  parameter int PER_GROUP   = 4,
  parameter int NUM_GROUPS  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [PER_GROUP-1:0]           rxLineClk,
  input  logic [PER_GROUP-1:0]           txLineClk,
  input  logic [PER_GROUP-1:0]           refClk,
  input  ctlStrobe_t                     strobes,
  output logic                           activeFlag
);
  localparam int TOTAL_SRC = PER_GROUP * NUM_GROUPS;

  logic [TOTAL_SRC-1:0]   allClk;
  logic                   selClk;
  logic                   togBit;
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncHist;
  logic                   edgeSeen;

  // Flatten the three groups: receive, transmit, reference.
  genvar g;
  generate
    for (g = 0; g < PER_GROUP; g++) begin : g_flat
      assign allClk[g]               = rxLineClk[g];
      assign allClk[PER_GROUP + g]   = txLineClk[g];
      assign allClk[2*PER_GROUP + g] = refClk[g];
    end
  endgenerate

  always_comb begin
    selClk = 1'b0;
    for (int i = 0; i < TOTAL_SRC; i++) begin
      if (int'(strobes.selIdx) == i) selClk = allClk[i];
    end
  end

  always_ff @(posedge selClk or negedge rstN) begin
    if (!rstN) togBit <= 1'b0;
    else       togBit <= ~togBit;
  end

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= togBit;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], togBit};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncHist <= 1'b0;
    else       syncHist <= syncChain[SYNC_STAGES-1];
  end

  assign edgeSeen = syncChain[SYNC_STAGES-1] ^ syncHist;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           activeFlag <= 1'b0;
    else if (strobes.clearFlag)          activeFlag <= 1'b0;
    else if (strobes.armed && edgeSeen)  activeFlag <= 1'b1;
  end

  // R3: a write clears the flag
  p_clear_on_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearFlag |=> !activeFlag);

  // R4: sticky until the next write
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (activeFlag && !strobes.clearFlag) |=> activeFlag);

  // R5: the flag rises only after an armed edge
  p_rise_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(activeFlag) |-> $past(strobes.armed && edgeSeen));

  // R6: invalid indices never report activity
  p_no_src_r6: assert property (@(posedge clk) disable iff (!rstN)
    (int'(strobes.selIdx) >= TOTAL_SRC) |-> !activeFlag);
endmodule

// File: rtl/clkActivityMonitor.sv
module clkActivityMonitor
  import clkact_pkg::*;
#(
  parameter int PER_GROUP   = 4,
  parameter int NUM_GROUPS  = 3,
  parameter int WINDOW_CYC  = 256,
  parameter int SETTLE_CYC  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PER_GROUP-1:0] rxLineClk,
  input  logic [PER_GROUP-1:0] txLineClk,
  input  logic [PER_GROUP-1:0] refClk,
  input  logic                 wrEn,
  input  logic [7:0]           wrData,
  output logic [7:0]           rdData
);
  localparam int TOTAL_SRC = PER_GROUP * NUM_GROUPS;
  localparam int FLAG_BIT  = 7;

  ctlStrobe_t strobes;
  logic       activeFlag;

  clkActControl #(
    .TOTAL_SRC (TOTAL_SRC),
    .WINDOW_CYC(WINDOW_CYC),
    .SETTLE_CYC(SETTLE_CYC),
    .DATA_W    (8)
  ) u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrData (wrData),
    .strobes(strobes)
  );

  clkActDatapath #(
    .PER_GROUP  (PER_GROUP),
    .NUM_GROUPS (NUM_GROUPS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .rxLineClk (rxLineClk),
    .txLineClk (txLineClk),
    .refClk    (refClk),
    .strobes   (strobes),
    .activeFlag(activeFlag)
  );

  always_comb begin
    rdData                = '0;
    rdData[SEL_W-1:0]     = strobes.selIdx;
    rdData[FLAG_BIT]      = activeFlag;
  end

  // R2: unused field bits stay zero
  p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdData[6:4] == 3'b000);

  // R9: reset state
  always_comb begin
    if (!rstN) p_reset_zero_r9: assert (rdData == 8'h00);
  end
endmodule

// File: tb/clkActivityMonitor_tb.sv
module clkActivityMonitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WINDOW = 256;
  localparam int SETTLE = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] rxLineClk, txLineClk, refClk;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;

  int  checks = 0;
  int  fails = 0;
  int  halfP[12];
  int  phaseCnt[12];
  logic lvl[12];

  // reference model state
  logic togM, muxPrev, s1, s2, s3, flagM;
  logic [3:0] selM;
  int   cntM;
  string tag = "R9";

  always #(CLK_PERIOD/2) clk = ~clk;

  clkActivityMonitor u_dut (
    .clk(clk), .rstN(rstN), .rxLineClk(rxLineClk), .txLineClk(txLineClk),
    .refClk(refClk), .wrEn(wrEn), .wrData(wrData), .rdData(rdData));

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      rxLineClk[i] = lvl[i];
      txLineClk[i] = lvl[4+i];
      refClk[i]    = lvl[8+i];
    end
  end

  function automatic logic muxOf(logic [3:0] s);
    return (s < 12) ? lvl[s] : 1'b0;
  endfunction

  task automatic modelMux();
    logic m;
    m = muxOf(selM);
    if (rstN && !muxPrev && m) togM = ~togM;
    muxPrev = m;
  endtask

  task automatic check(string t, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s rdData=%h expected %h at %0t", t, act, exp, $time);
    end
  endtask

  // candidate clocks advance only on falling edges of clk
  always @(negedge clk) begin
    for (int i = 0; i < 12; i++) begin
      if (halfP[i] > 0) begin
        phaseCnt[i]++;
        if (phaseCnt[i] >= halfP[i]) begin
          lvl[i] = ~lvl[i];
          phaseCnt[i] = 0;
        end
      end
    end
    #0;
    modelMux();
  end

  // behavioural model advanced just after each rising edge
  always @(posedge clk) begin
    logic edgeM, armedM;
    #1;
    if (!rstN) begin
      togM = 0; s1 = 0; s2 = 0; s3 = 0; flagM = 0; selM = 0; cntM = WINDOW;
    end else begin
      edgeM  = (s2 != s3);
      armedM = (cntM >= SETTLE) && (cntM < WINDOW) && (selM < 12);
      s3 = s2; s2 = s1; s1 = togM;
      if (wrEn) begin
        selM = wrData[3:0]; flagM = 0; cntM = 0;
      end else begin
        if (armedM && edgeM) flagM = 1;
        if (cntM < WINDOW) cntM++;
      end
      modelMux();
      check({tag, " model"}, rdData, {flagM, 3'b000, selM});
    end
  end

  task automatic writeIdx(logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1 clock plan: 0 means stopped
    int hp[12] = '{1, 3, 0, 5, 0, 2, 0, 7, 4, 0, 1, 0};
    for (int i = 0; i < 12; i++) begin
      halfP[i] = hp[i]; phaseCnt[i] = 0; lvl[i] = 1'b0;
    end
    lvl[4] = 1'b1; // transmit clock 0 stopped high (R7 case)
    togM = 0; muxPrev = 0; s1 = 0; s2 = 0; s3 = 0; flagM = 0; selM = 0; cntM = WINDOW;
    waitCyc(4);
    #1 check("R9 reset", rdData, 8'h00);
    @(negedge clk); rstN = 1'b1;
    waitCyc(2);

    // R1 / R2 / R6: sweep every index, with upper write bits set
    tag = "R1";
    for (int idx = 0; idx < 16; idx++) begin
      logic expAct;
      writeIdx({4'b1010, 4'(idx)});
      check("R2 field", rdData, {1'b0, 3'b000, 4'(idx)});
      waitCyc(40);
      expAct = (idx < 12) && (hp[idx] > 0);
      check(idx >= 12 ? "R6 no source" : "R1 activity", rdData,
            {expAct, 3'b000, 4'(idx)});
    end

    // R7: switch from no-source to a clock held high
    tag = "R7";
    writeIdx(8'h0C);
    writeIdx(8'h04);
    waitCyc(40);
    check("R7 switch glitch ignored", rdData, 8'h04);

    // R8: clock starts after the window has closed
    tag = "R8";
    writeIdx(8'h0B);
    waitCyc(WINDOW + 20);
    halfP[11] = 2;
    waitCyc(30);
    check("R8 late clock ignored", rdData, 8'h0B);
    writeIdx(8'h0B);
    waitCyc(40);
    check("R3 rewrite restarts window", rdData, 8'h8B);

    // R4: flag sticks after the clock stops
    tag = "R4";
    writeIdx(8'h00);
    waitCyc(20);
    check("R4 set", rdData, 8'h80);
    halfP[0] = 0;
    waitCyc(60);
    check("R4 sticky after stop", rdData, 8'h80);

    // R3: write clears
    tag = "R3";
    writeIdx(8'h00);
    check("R3 cleared", rdData, 8'h00);
    waitCyc(40);
    check("R3 stays clear, clock stopped", rdData, 8'h00);

    // R5: timing of detection follows the model on every cycle
    tag = "R5";
    writeIdx(8'h08);
    waitCyc(40);
    check("R5 reference clock", rdData, 8'h88);

    waitCyc(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule